// File: doc/BRIEF.md
# Serial Configuration Bitstream Memory

This block is a read-only memory with a one-bit-wide output that streams a stored configuration image to a master device. The master supplies the clock. Each qualified rising edge moves the read point by one bit. The read point is formed by a byte address counter and a bit-within-byte counter, and each byte is sent most-significant bit first. The image is fixed at elaboration time by a package function, so the array needs no load path.

Two control inputs govern the block:

- **Active-low chip enable.** While it is high, the block is in standby. Both counters are held at zero and the output is released, whatever the other input does.
- **Combined reset/output-enable input.** Its polarity is chosen by a parameter. When this input is in its reset level, the counters are cleared and held, and the output is released. When it is in the other level, output is enabled.

A terminal-count flag rises once the final bit has been clocked out. After that the read point freezes until a clear. The floating output is represented by a drive-enable flag next to the data bit, so the block stays synthesizable inside a larger chip.

Top module: `serial_cfg_rom`

## Requirements
- R1: With chip enable active (`ce_n` low) and output enable active, each rising `clk` edge advances the read position by exactly one bit, until terminal count is reached.
- R2: While `rst_oe` is at its reset level, the read position is held at zero, `tc` is low and `data_oe` is low.
- R3: With `RST_ACTIVE_HIGH`=1, the reset level of `rst_oe` is 1 and the enable level is 0. With `RST_ACTIVE_HIGH`=0, the two levels are swapped.
- R4: While `ce_n` is 1, the read position is held at zero, `tc` is low and `data_oe` is low, whatever level `rst_oe` has.
- R5: `data_oe` is 1 exactly when `ce_n` is 0 and `rst_oe` is at its enable level.
- R6: Read position p presents bit (7 - p mod 8) of stored byte floor(p/8) on `data_out`. Byte k holds ((k*29) mod 256) XOR 0xA5 XOR (floor(k/2) mod 256).
- R7: The position of the final bit is 8*`NUM_BYTES`-1. On the qualified edge taken at that position, `tc` becomes 1. While `tc` is 1, the position no longer changes, `tc` stays 1 until a clear by R2 or R4, and `data_out` is 0.
- R8: `data_out` is 0 whenever `data_oe` is 0.
- R9: `standby` equals `ce_n` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock from the master device |
| rst_oe | input | 1 | Combined reset/output enable; polarity set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Chip enable, active low; high forces standby and clear |
| data_out | output | 1 | Serial data bit, MSB of each byte first |
| data_oe | output | 1 | Drive enable for `data_out`; low stands for high impedance |
| tc | output | 1 | Terminal count: final bit has been sent |
| standby | output | 1 | High while the block is in standby |

## Verification
The clear path is asynchronous and is decoded from the two control inputs. The clocked properties therefore assume that those inputs never change at a rising clock edge. Under that assumption, the value sampled at an edge is the value that acted on the counters. The bench meets this by changing `ce_n` and `rst_oe` only on falling edges.

Random stimulus keeps `ce_n` and the reset level rare, so that long enabled runs occur. A directed run of more than 8*`NUM_BYTES` qualified edges reaches terminal count. A second instance with the opposite polarity receives the inverted `rst_oe` and must match the same expected values.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  // stored image, computed at elaboration
  function automatic logic [BYTE_W-1:0] rom_byte(input int unsigned k);
    logic [BYTE_W-1:0] prod;
    logic [BYTE_W-1:0] half;
    prod = BYTE_W'(k * 29);
    half = BYTE_W'(k >> 1);
    return prod ^ 8'hA5 ^ half;
  endfunction

  // flat bit position from byte address and bit index
  function automatic int unsigned flat_pos(input int unsigned addr, input int unsigned bidx);
    return addr * BYTE_W + bidx;
  endfunction

  // bit lane selected for a bit index, MSB first
  function automatic logic [BIT_W-1:0] lane_of(input logic [BIT_W-1:0] bidx);
    return BIT_W'(BYTE_W - 1) - bidx;
  endfunction

endpackage

// File: rtl/cfg_pin_decode.sv
module cfg_pin_decode #(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic rst_oe_i,
  input  logic ce_n_i,
  output logic rst_act_o,
  output logic rd_en_o,
  output logic clr_o
);

  logic rst_act;

  generate
    if (RST_ACTIVE_HIGH) begin : g_pol_high
      assign rst_act = rst_oe_i;
    end else begin : g_pol_low
      assign rst_act = ~rst_oe_i;
    end
  endgenerate

  assign rst_act_o = rst_act;
  assign rd_en_o   = ~ce_n_i & ~rst_act;
  assign clr_o     = ce_n_i | rst_act;

  // R5: read enable never while chip enable is off
  always_comb begin
    a_r5_no_read_in_standby: assert (!(ce_n_i && rd_en_o));
  end

endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter
  import cfg_rom_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              done_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_BYTES - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);

  logic [ADDR_W-1:0] addr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              done_q;
  logic              step;
  logic              wrap;
  int unsigned       pos_now;

  assign last_o  = (addr_q == LAST_ADDR) && (bit_q == LAST_BIT);
  assign wrap    = (bit_q == LAST_BIT);
  assign step    = adv_i && !done_q;
  assign pos_now = flat_pos(32'(addr_q), 32'(bit_q));

  always_ff @(posedge clk or posedge clr_i) begin
    if (clr_i) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      if (last_o) begin
        done_q <= 1'b1;
      end else if (wrap) begin
        bit_q  <= '0;
        addr_q <= addr_q + 1'b1;
      end else begin
        bit_q  <= bit_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;

  // R1: one position per qualified edge
  a_r1_advance_one: assert property (@(posedge clk) disable iff (clr_i)
    (adv_i && !done_q && !last_o) |=> (pos_now == $past(pos_now) + 1));

  // R1: no movement without a read enable
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (clr_i)
    !adv_i |=> ($stable(pos_now) && $stable(done_q)));

  // R7: terminal count is sticky and freezes the position
  a_r7_tc_sticky: assert property (@(posedge clk) disable iff (clr_i)
    done_q |=> (done_q && $stable(pos_now)));

  // R7: terminal count is entered only from the final position
  a_r7_tc_from_last: assert property (@(posedge clk) disable iff (clr_i)
    $rose(done_q) |-> last_o);

  // R2: clear holds the counters at zero
  a_r2_clear_zero: assert property (@(posedge clk)
    clr_i |-> (pos_now == 0 && !done_q));

endmodule

// File: rtl/cfg_rom_array.sv
module cfg_rom_array
  import cfg_rom_pkg::*;
#(
  parameter int NUM_BYTES = 16,
  parameter int ADDR_W    = $clog2(NUM_BYTES)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              bit_o
);

  logic [BYTE_W-1:0] mem [NUM_BYTES];
  logic [BYTE_W-1:0] word;

  generate
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_word
      assign mem[k] = rom_byte(k);
    end
  endgenerate

  always_comb begin
    word = '0;
    if (32'(addr_i) < NUM_BYTES) word = mem[addr_i];
  end

  assign bit_o = word[lane_of(bit_i)];

endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom
  import cfg_rom_pkg::*;
#(
  parameter int NUM_BYTES       = 16,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_oe,
  input  logic ce_n,
  output logic data_out,
  output logic data_oe,
  output logic tc,
  output logic standby
);

  localparam int ADDR_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  logic              rst_act;
  logic              rd_en;
  logic              clr;
  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bidx;
  logic              done;
  logic              last;
  logic              rom_bit;

  cfg_pin_decode #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_dec (
    .rst_oe_i (rst_oe),
    .ce_n_i   (ce_n),
    .rst_act_o(rst_act),
    .rd_en_o  (rd_en),
    .clr_o    (clr)
  );

  cfg_bit_counter #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_cnt (
    .clk   (clk),
    .clr_i (clr),
    .adv_i (rd_en),
    .addr_o(addr),
    .bit_o (bidx),
    .done_o(done),
    .last_o(last)
  );

  cfg_rom_array #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_rom (
    .addr_i(addr),
    .bit_i (bidx),
    .bit_o (rom_bit)
  );

  assign data_oe  = rd_en;
  assign data_out = rd_en & ~done & rom_bit;
  assign tc       = done;
  assign standby  = ce_n;

  // R4: standby releases the output and clears terminal count
  a_r4_standby_float: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |-> (!data_oe && !tc && standby));

  // R8: no data while the output is released
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst_act)
    !data_oe |-> !data_out);

  // R7: data is zero once terminal count is set
  a_r7_quiet_after_tc: assert property (@(posedge clk) disable iff (rst_act)
    tc |-> !data_out);

  // R2: reset level releases the output
  a_r2_reset_float: assert property (@(posedge clk) disable iff (ce_n)
    rst_act |-> (!data_oe && !tc));

  // R9: standby tracks chip enable
  always_comb begin
    a_r9_standby_pin: assert (standby == ce_n);
  end

endmodule

// File: tb/sim_serial_cfg_rom.sv
`timescale 1ns/100ps
module sim_serial_cfg_rom;

  localparam int NB   = 16;
  localparam int NBIT = NB * 8;

  logic clk = 1'b0;
  logic rst_a, rst_b, ce_n;
  logic dout_a, oe_a, tc_a, sb_a;
  logic dout_b, oe_b, tc_b, sb_b;

  int nchk = 0;
  int nfail = 0;
  int m_pos = 0;
  bit m_done = 1'b0;

  always #2 clk = ~clk;

  serial_cfg_rom #(.NUM_BYTES(NB), .RST_ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rst_oe(rst_a), .ce_n(ce_n),
    .data_out(dout_a), .data_oe(oe_a), .tc(tc_a), .standby(sb_a));

  serial_cfg_rom #(.NUM_BYTES(NB), .RST_ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rst_oe(rst_b), .ce_n(ce_n),
    .data_out(dout_b), .data_oe(oe_b), .tc(tc_b), .standby(sb_b));

  function automatic int exp_byte(input int k);
    return ((k * 29) % 256) ^ 165 ^ ((k / 2) % 256);
  endfunction

  function automatic bit exp_bit(input int p);
    int b;
    b = exp_byte(p / 8);
    return bit'((b / (1 << (7 - (p % 8)))) % 2);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at pos %0d", tag, act, exp, m_pos);
    end
  endtask

  task automatic check_all(input logic cen, input logic rst);
    logic e_oe, e_dat;
    string tag;
    e_oe  = !cen && !rst;
    e_dat = e_oe && !m_done && exp_bit(m_pos);
    if (cen) tag = "R4";
    else if (rst) tag = "R2";
    else if (m_done) tag = "R7";
    else tag = "R1,R6";
    chk({tag, " R5 data_oe"}, oe_a, e_oe);
    chk({tag, " data_out"}, dout_a, e_dat);
    chk({tag, " tc"}, tc_a, m_done);
    chk("R9 standby", sb_a, cen);
    if (!e_oe) chk("R8 data_out off", dout_a, 1'b0);
    chk("R3 data_oe inverted polarity", oe_b, e_oe);
    chk("R3 data_out inverted polarity", dout_b, e_dat);
    chk("R3 tc inverted polarity", tc_b, m_done);
    chk("R3 R9 standby", sb_b, cen);
  endtask

  task automatic run_cycle(input logic cen, input logic rst);
    @(negedge clk);
    ce_n  = cen;
    rst_a = rst;
    rst_b = ~rst;
    if (cen || rst) begin
      m_pos  = 0;
      m_done = 1'b0;
    end
    #1 check_all(cen, rst);
    @(posedge clk);
    if (!cen && !rst && !m_done) begin
      if (m_pos == NBIT - 1) m_done = 1'b1;
      else m_pos++;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    ce_n  = 1'b1;
    rst_a = 1'b1;
    rst_b = 1'b0;
    // reset state (R2, R4)
    for (int i = 0; i < 3; i++) run_cycle(1'b0, 1'b1);
    for (int i = 0; i < 2; i++) run_cycle(1'b1, 1'b1);
    // full stream to terminal count and beyond (R1, R6, R7)
    for (int i = 0; i < NBIT + 12; i++) run_cycle(1'b0, 1'b0);
    // terminal count cleared by standby with output enable inactive (R4)
    run_cycle(1'b1, 1'b0);
    run_cycle(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) run_cycle(1'b0, 1'b0);
    // reset in mid stream (R2)
    run_cycle(1'b0, 1'b1);
    for (int i = 0; i < NBIT + 4; i++) run_cycle(1'b0, 1'b0);
    // reset clears terminal count (R2, R7)
    run_cycle(1'b0, 1'b1);
    run_cycle(1'b0, 1'b0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic rc, rr;
      rc = (($urandom % 64) == 0);
      rr = (($urandom % 96) == 0);
      run_cycle(rc, rr);
    end
    finish_run();
  end

endmodule